// File: doc/BRIEF.md
# Panel Controller Power-Up Sequencer

This block brings a small serial TFT panel controller from power-on to a state where it accepts pixel data. A one-cycle `start` pulse first holds the panel's reset line low for a fixed time. The block then lowers chip select and plays a fixed script of command bytes and parameter bytes, with the waits the panel needs. Each byte goes out over a byte-wide valid/ready port to an external serial shifter. A flag beside the byte tells the shifter whether the byte is a command or a parameter.

The script is held in a small internal table. Each entry is a byte with its kind, or a marker for a long wait or a short wait. Wait lengths are given in milliseconds and turned into clock cycles from the `CLK_HZ` parameter. The script ends by selecting memory-write mode, so the next bytes the panel receives are pixels. A one-cycle `done` pulse then marks the end, and the block returns to idle.

Top module: `lcd_boot_seq`

## Requirements
- R1: After reset, and while idle, `cs_n` is 1, `panel_rst_n` is 1, `tx_valid` is 0 and `done` is 0.
- R2: A `start` pulse in idle drives `panel_rst_n` to 0 for exactly RST_MS*CLK_HZ/1000 cycles. No byte is offered during that time. Bytes follow when the reset phase ends.
- R3: The bytes are offered in this fixed order:
  - 01, then 11
  - 3A with parameter 05
  - 26 with parameter 02
  - 13
  - B6 with parameters FF 06
  - B1 with parameters 08 02
  - B4 with parameter 07
  - C0 with parameters 0A 02
  - C1 with parameter 02
  - C5 with parameters 50 63
  - C7 with parameter 00
  - 2A with parameters 00 00 00 80
  - 2B with parameters 00 00 00 80
  - 29, then 2C
- R4: `tx_dc` is 0 for a command byte and 1 for a parameter byte.
- R5: After byte 01 is accepted, `tx_valid` stays 0 for exactly LONG_MS*CLK_HZ/1000 cycles before byte 11 is offered. After byte 11, it stays 0 for exactly SHORT_MS*CLK_HZ/1000 cycles. No other gap occurs between bytes.
- R6: A byte is transferred only on a clock edge where `tx_valid` and `tx_ready` are both 1. While `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_dc` hold their values.
- R7: `cs_n` goes to 0 when the first byte is offered. It stays 0 through all bytes and waits until the last byte is accepted.
- R8: `done` is 1 for exactly one cycle, the cycle after byte 2C is accepted, with `cs_n` back at 1. The block is then idle and accepts a new `start`.
- R9: A `start` pulse while a sequence is running has no effect on the bytes or on their timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run the sequence |
| tx_ready | input | 1 | Shifter can take a byte |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| cs_n | output | 1 | Panel chip select, active low |
| panel_rst_n | output | 1 | Panel hardware reset, active low |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A wrong table index shows at the ports as soon as the next byte is offered: the byte or its command/parameter flag differs from the expected stream. A wrong wait counter shows as a gap of the wrong length before byte 11 or byte 3A. Those gaps are measured to the exact cycle. A wrong state shows as `cs_n` or `panel_rst_n` at the wrong level, or as `done` outside the single cycle after the last byte. The same stream is checked under stalled and free-flowing ready patterns, and with a `start` pulse injected while a sequence runs.

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int RST_MS   = 10,
  parameter int LONG_MS  = 500,
  parameter int SHORT_MS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_dc,
  output logic       cs_n,
  output logic       panel_rst_n,
  output logic       done
);
  localparam int CPMS      = CLK_HZ / 1000;
  localparam int RST_CYC   = RST_MS * CPMS;
  localparam int LONG_CYC  = LONG_MS * CPMS;
  localparam int SHORT_CYC = SHORT_MS * CPMS;
  localparam int MAXC      = (RST_CYC > LONG_CYC) ? RST_CYC : LONG_CYC;
  localparam int CW        = $clog2(MAXC + 1);
  localparam int LAST      = 38;
  localparam int IW        = 6;
  localparam logic [CW-1:0] RST_T   = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] LONG_T  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_T = CW'(SHORT_CYC - 1);

  localparam logic [1:0] K_CMD = 2'b00, K_PAR = 2'b01, K_DLY = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_HWRST, S_RUN, S_FIN} st_t;
  st_t st;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;

  function automatic logic [9:0] step(input logic [IW-1:0] i);
    case (i)
      6'd0:  step = {K_CMD, 8'h01};
      6'd1:  step = {K_DLY, 8'h00};
      6'd2:  step = {K_CMD, 8'h11};
      6'd3:  step = {K_DLY, 8'h01};
      6'd4:  step = {K_CMD, 8'h3A};
      6'd5:  step = {K_PAR, 8'h05};
      6'd6:  step = {K_CMD, 8'h26};
      6'd7:  step = {K_PAR, 8'h02};
      6'd8:  step = {K_CMD, 8'h13};
      6'd9:  step = {K_CMD, 8'hB6};
      6'd10: step = {K_PAR, 8'hFF};
      6'd11: step = {K_PAR, 8'h06};
      6'd12: step = {K_CMD, 8'hB1};
      6'd13: step = {K_PAR, 8'h08};
      6'd14: step = {K_PAR, 8'h02};
      6'd15: step = {K_CMD, 8'hB4};
      6'd16: step = {K_PAR, 8'h07};
      6'd17: step = {K_CMD, 8'hC0};
      6'd18: step = {K_PAR, 8'h0A};
      6'd19: step = {K_PAR, 8'h02};
      6'd20: step = {K_CMD, 8'hC1};
      6'd21: step = {K_PAR, 8'h02};
      6'd22: step = {K_CMD, 8'hC5};
      6'd23: step = {K_PAR, 8'h50};
      6'd24: step = {K_PAR, 8'h63};
      6'd25: step = {K_CMD, 8'hC7};
      6'd26: step = {K_PAR, 8'h00};
      6'd27: step = {K_CMD, 8'h2A};
      6'd28: step = {K_PAR, 8'h00};
      6'd29: step = {K_PAR, 8'h00};
      6'd30: step = {K_PAR, 8'h00};
      6'd31: step = {K_PAR, 8'h80};
      6'd32: step = {K_CMD, 8'h2B};
      6'd33: step = {K_PAR, 8'h00};
      6'd34: step = {K_PAR, 8'h00};
      6'd35: step = {K_PAR, 8'h00};
      6'd36: step = {K_PAR, 8'h80};
      6'd37: step = {K_CMD, 8'h29};
      default: step = {K_CMD, 8'h2C};
    endcase
  endfunction

  logic [9:0]    ent;
  logic          is_dly;
  logic [CW-1:0] dly_t;

  assign ent    = step(idx);
  assign is_dly = ent[9:8] == K_DLY;
  assign dly_t  = ent[0] ? SHORT_T : LONG_T;

  assign tx_valid    = (st == S_RUN) && !is_dly;
  assign tx_data     = ent[7:0];
  assign tx_dc       = ent[9:8] == K_PAR;
  assign cs_n        = st != S_RUN;
  assign panel_rst_n = st != S_HWRST;
  assign done        = st == S_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_HWRST;
          idx <= '0;
          cnt <= '0;
        end
        S_HWRST: if (cnt == RST_T) begin
          cnt <= '0;
          st  <= S_RUN;
        end else cnt <= cnt + 1'b1;
        S_RUN: if (is_dly) begin
          if (cnt == dly_t) begin
            cnt <= '0;
            idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end else if (tx_ready) begin
          if (idx == IW'(LAST)) st <= S_FIN;
          else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module lcd_boot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_dc,
  input logic       cs_n,
  input logic       panel_rst_n,
  input logic       done
);
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_dc));
  a_r7_cs_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cs_n);
  a_r2_no_byte_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !tx_valid && cs_n);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && !tx_valid);
  a_r7_cs_falls_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> tx_valid);
endmodule

bind lcd_boot_seq lcd_boot_seq_chk u_chk (.*);

// File: tb/sim_lcd_boot_seq.sv
module sim_lcd_boot_seq;
  localparam int CLK_HZ = 100_000;
  localparam int RST_MS = 2, LONG_MS = 500, SHORT_MS = 5;
  localparam int RST_CYC = RST_MS * CLK_HZ / 1000;
  localparam int LONG_CYC = LONG_MS * CLK_HZ / 1000;
  localparam int SHORT_CYC = SHORT_MS * CLK_HZ / 1000;

  logic clk = 0, rst_n = 0, start = 0, tx_ready = 0;
  logic tx_valid, tx_dc, cs_n, panel_rst_n, done;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0;
  logic [8:0] q_item[$];
  int q_gap[$];
  int gap = 0, rst_len = 0, done_cnt = 0;
  bit await_done = 0;
  bit ready_mode = 0;
  bit in_rst = 0;

  always #10 clk = ~clk;

  lcd_boot_seq #(.CLK_HZ(CLK_HZ), .RST_MS(RST_MS), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_dc(tx_dc), .cs_n(cs_n), .panel_rst_n(panel_rst_n), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit dc, input logic [7:0] b, input int g);
    q_item.push_back({dc, b});
    q_gap.push_back(g);
  endtask

  task automatic cmd(input logic [7:0] b, input int g = 0);
    push(1'b0, b, g);
  endtask

  task automatic par(input logic [7:0] b);
    push(1'b1, b, 0);
  endtask

  task automatic load_script;
    cmd(8'h01); cmd(8'h11, LONG_CYC); cmd(8'h3A, SHORT_CYC); par(8'h05);
    cmd(8'h26); par(8'h02); cmd(8'h13);
    cmd(8'hB6); par(8'hFF); par(8'h06);
    cmd(8'hB1); par(8'h08); par(8'h02);
    cmd(8'hB4); par(8'h07);
    cmd(8'hC0); par(8'h0A); par(8'h02);
    cmd(8'hC1); par(8'h02);
    cmd(8'hC5); par(8'h50); par(8'h63);
    cmd(8'hC7); par(8'h00);
    cmd(8'h2A); par(8'h00); par(8'h00); par(8'h00); par(8'h80);
    cmd(8'h2B); par(8'h00); par(8'h00); par(8'h00); par(8'h80);
    cmd(8'h29); cmd(8'h2C);
  endtask

  // ready pattern driver, changes just after rising edges
  int rcnt = 0;
  always @(posedge clk) begin
    #1;
    rcnt++;
    tx_ready = ready_mode ? 1'b1 : (rcnt % 3 != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (!panel_rst_n) begin
      rst_len++;
      in_rst = 1;
      chk(!tx_valid, "R2 byte during reset", tx_valid, 0);
    end else if (in_rst) begin
      in_rst = 0;
      chk(rst_len == RST_CYC, "R2 reset width", rst_len, RST_CYC);
      rst_len = 0;
    end
    if (await_done) begin
      await_done = 0;
      chk(done === 1'b1 && cs_n === 1'b1, "R8 done after last byte", {done, cs_n}, 2'b11);
    end else if (done) begin
      chk(0, "R8 unexpected done", done, 0);
    end
    if (done) done_cnt++;
    if (!cs_n && !tx_valid) gap++;
    if (tx_valid) chk(!cs_n, "R7 cs low with byte", cs_n, 0);
    if (tx_valid && tx_ready) begin
      if (q_item.size() == 0) chk(0, "R3 extra byte", {tx_dc, tx_data}, 0);
      else begin
        logic [8:0] e;
        int eg;
        e = q_item.pop_front();
        eg = q_gap.pop_front();
        chk(tx_data == e[7:0], "R3 byte order", tx_data, e[7:0]);
        chk(tx_dc == e[8], "R4 dc flag", tx_dc, e[8]);
        chk(gap == eg, "R5 gap before byte", gap, eg);
        if (q_item.size() == 0) await_done = 1;
      end
      gap = 0;
    end
  end

  // R6 stall hold check
  logic [8:0] prev_item;
  bit prev_stall = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_stall)
      chk(tx_valid && {tx_dc, tx_data} == prev_item, "R6 hold during stall", {tx_dc, tx_data}, prev_item);
    prev_stall = tx_valid && !tx_ready;
    prev_item = {tx_dc, tx_data};
  end

  task automatic pulse_start;
    @(posedge clk); #2 start = 1;
    @(posedge clk); #2 start = 0;
  endtask

  task automatic wait_done;
    while (!(q_item.size() == 0 && !await_done && done_cnt > 0)) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(cs_n && panel_rst_n && !tx_valid && !done, "R1 reset state",
        {cs_n, panel_rst_n, tx_valid, done}, 4'b1100);
    // run 1: stalled ready, extra start mid-run (R9)
    load_script;
    gap = 0;
    pulse_start;
    repeat (RST_CYC + 200) @(posedge clk);
    pulse_start; // R9: ignored while busy
    wait_done;
    chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
    @(negedge clk);
    chk(!done && cs_n && panel_rst_n && !tx_valid, "R1 idle after done",
        {done, cs_n, panel_rst_n, tx_valid}, 4'b0110);
    chk(q_item.size() == 0, "R9 stream complete", q_item.size(), 0);
    // run 2: ready always high
    ready_mode = 1;
    done_cnt = 0;
    load_script;
    gap = 0;
    pulse_start;
    wait_done;
    chk(done_cnt == 1, "R8 one done pulse run 2", done_cnt, 1);
    repeat (5) @(negedge clk);
    chk(!tx_valid && cs_n && done_cnt == 1, "R1 stays idle", {tx_valid, cs_n}, 2'b01);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule